// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Frozen Register View

This block keeps calendar time from hundredths of a second up to a two-digit year, all in packed BCD and 24-hour form. It holds two copies of the time: a set of internal counters that advance on every 100 Hz tick enable, and a bank of host-visible registers behind a simple register port. Once per second, when the hundredths count wraps, the visible bank takes a fresh copy of the counters. This means the host always sees a coherent snapshot and never sees a value half way through a carry.

Two hold bits in a control register decide which way copies flow. The read hold stops the refresh so the host can collect a multi-byte time at leisure, while the counters keep running. The write hold also stops the refresh and opens the time registers to host writes. Clearing the write hold pushes the written values into the counters. A stop bit halts counting. A test bit replaces the seconds LSB seen on reads with a square wave driven by a separate 512 Hz tick, so the base rate can be measured.

Top module: `rtc_frozen_view_clock`

## Requirements
- R1: After reset, reads return hundredths 00, seconds 00, minutes 00, hours 00, weekday 01, date 01, month 01, year 00 and control 00. Register offsets are 0 hundredths, 1 seconds (bit 7 = stop), 2 minutes, 3 hours, 4 weekday (bits 2:0; bit 6 = test enable), 5 date, 6 month, 7 year and 8 control (bit 7 = write hold, bit 6 = read hold). Any other offset reads 00.
- R2: Each cycle with tick_100 high and the stop bit clear advances the internal time by 0.01 s in BCD. Carries follow these ranges: hundredths 00–99, seconds and minutes 00–59, hours 00–23.
- R3: At the clock edge where the internal hundredths wrap from 99 to 00, every visible time register takes the new counter value at once, provided neither hold bit was set before that edge. At no other edge does a refresh change them.
- R4: While the read hold is 1, the visible time does not change. The counters keep counting, so the first refresh after the hold is released shows the time advanced by the full elapsed interval.
- R5: A control write that sets a hold bit in the same cycle as a wrap does not cancel the refresh of that cycle. The freeze starts from the following edge.
- R6: Writes to offsets 0–7 change the time fields only when the write hold was already 1. Other time-field writes are ignored. While the write hold is 1, no refresh occurs.
- R7: A control write that clears a set write hold loads all visible time values into the counters at that edge. The next refresh then continues from the loaded time.
- R8: The stop bit in seconds bit 7 can be written at any time. While it is 1, tick_100 is ignored and no refresh occurs. Once it is cleared, counting resumes and a refresh follows within 100 ticks.
- R9: The test enable in weekday bit 6 changes only under the write hold. While it is 1, seconds bit 0 on reads shows a toggle bit. That bit starts at 0 from reset and inverts on every tick_512 pulse.
- R10: At midnight the weekday goes from 07 to 01 and the date wraps past the month's last day. Months have 31 days, except April, June, September and November with 30 and February with 28, or 29 when the year is divisible by 4. Month 12 wraps to 01, and year 99 wraps to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100 | input | 1 | 100 Hz count enable, one cycle wide |
| tick_512 | input | 1 | 512 Hz test tick, one cycle wide |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data at reg_addr |

## Verification
The range property on the counters assumes the host writes only valid packed BCD within each field's range while the write hold is set. The stimulus therefore loads only legal dates and times, such as month ends, leap and non-leap Februaries and the last second of a century. The refresh and freeze properties assume tick_100 is a single-cycle pulse, which every tick task in the bench respects. Stimulus is driven on the falling clock edge so that holds and ticks land on well-defined rising edges, including the case where a hold and a wrap coincide.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

   typedef struct packed {
      logic [7:0] yr;
      logic [7:0] mon;
      logic [7:0] date;
      logic [7:0] dow;
      logic [7:0] hr;
      logic [7:0] min;
      logic [7:0] sec;
      logic [7:0] hund;
   } rtc_time_t;

   localparam rtc_time_t RTC_EPOCH = '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                                       hr: 8'h00, min: 8'h00, sec: 8'h00, hund: 8'h00};

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
      else                return {v[7:4], v[3:0] + 4'h1};
   endfunction

   function automatic logic leap_year(input logic [7:0] yr);
      logic [5:0] s;
      s = {1'b0, yr[7:4], 1'b0} + {2'b00, yr[3:0]};
      return (s[1:0] == 2'b00);
   endfunction

   function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic logic bcd_ok(input logic [7:0] v, input logic [7:0] lo, input logic [7:0] hi);
      return (v[3:0] <= 4'h9) && (v >= lo) && (v <= hi);
   endfunction

   function automatic logic time_ok(input rtc_time_t t);
      return bcd_ok(t.hund, 8'h00, 8'h99) && bcd_ok(t.sec, 8'h00, 8'h59) &&
             bcd_ok(t.min, 8'h00, 8'h59) && bcd_ok(t.hr, 8'h00, 8'h23) &&
             bcd_ok(t.dow, 8'h01, 8'h07) && bcd_ok(t.date, 8'h01, 8'h31) &&
             bcd_ok(t.mon, 8'h01, 8'h12) && bcd_ok(t.yr, 8'h00, 8'h99);
   endfunction

endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
   import rtc_bcd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      run,
   input  logic      load,
   input  rtc_time_t load_time,
   output rtc_time_t cur_time,
   output rtc_time_t nxt_time,
   output logic      roll_now
);

   rtc_time_t cnt_q;
   rtc_time_t nxt;
   logic      step;

   assign step = tick && run;

   always_comb begin
      nxt = cnt_q;
      if (step) begin
         if (cnt_q.hund != 8'h99) nxt.hund = bcd_inc(cnt_q.hund);
         else begin
            nxt.hund = 8'h00;
            if (cnt_q.sec != 8'h59) nxt.sec = bcd_inc(cnt_q.sec);
            else begin
               nxt.sec = 8'h00;
               if (cnt_q.min != 8'h59) nxt.min = bcd_inc(cnt_q.min);
               else begin
                  nxt.min = 8'h00;
                  if (cnt_q.hr != 8'h23) nxt.hr = bcd_inc(cnt_q.hr);
                  else begin
                     nxt.hr  = 8'h00;
                     nxt.dow = (cnt_q.dow == 8'h07) ? 8'h01 : bcd_inc(cnt_q.dow);
                     if (cnt_q.date != month_len(cnt_q.mon, cnt_q.yr)) nxt.date = bcd_inc(cnt_q.date);
                     else begin
                        nxt.date = 8'h01;
                        if (cnt_q.mon != 8'h12) nxt.mon = bcd_inc(cnt_q.mon);
                        else begin
                           nxt.mon = 8'h01;
                           nxt.yr  = (cnt_q.yr == 8'h99) ? 8'h00 : bcd_inc(cnt_q.yr);
                        end
                     end
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= RTC_EPOCH;
      else if (load) cnt_q <= load_time;
      else           cnt_q <= nxt;
   end

   assign cur_time = cnt_q;
   assign nxt_time = nxt;
   assign roll_now = step && (cnt_q.hund == 8'h99);

   // R2: counters stay legal packed BCD in range
   a_r2_fields_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      time_ok(cnt_q));

   // R8: with the stop bit set the counters hold still
   a_r8_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(cnt_q));

   // R7: a load takes the host-written time
   a_r7_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_time)));

endmodule

// File: rtl/rtc_ftest_toggle.sv
module rtc_ftest_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic tog
);

   logic tog_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    tog_q <= 1'b0;
      else if (tick) tog_q <= ~tog_q;
   end

   assign tog = tog_q;

   // R9: toggle moves only on a test tick
   a_r9_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(tog_q));

endmodule

// File: rtl/rtc_view_regs.sv
module rtc_view_regs
   import rtc_bcd_pkg::*;
#(
   parameter int   ADDR_W        = 4,
   parameter logic RESET_STOPPED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              roll_now,
   input  rtc_time_t         nxt_time,
   input  logic              ft_tog,
   output logic              osc_stop,
   output logic              load,
   output rtc_time_t         load_time
);

   localparam logic [ADDR_W-1:0] OFS_HUND = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] OFS_SEC  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] OFS_MIN  = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] OFS_HR   = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] OFS_DOW  = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] OFS_DATE = ADDR_W'(5);
   localparam logic [ADDR_W-1:0] OFS_MON  = ADDR_W'(6);
   localparam logic [ADDR_W-1:0] OFS_YR   = ADDR_W'(7);
   localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8);
   localparam int WR_HOLD_BIT = 7;
   localparam int RD_HOLD_BIT = 6;

   rtc_time_t  vis_q;
   logic [7:0] ctrl_q;
   logic       stop_q;
   logic       ft_q;
   logic       wr_hold;
   logic       any_hold;

   assign wr_hold  = ctrl_q[WR_HOLD_BIT];
   assign any_hold = ctrl_q[WR_HOLD_BIT] | ctrl_q[RD_HOLD_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vis_q  <= RTC_EPOCH;
         ctrl_q <= 8'h00;
         stop_q <= RESET_STOPPED;
         ft_q   <= 1'b0;
      end else begin
         if (roll_now && !any_hold) vis_q <= nxt_time;
         if (reg_we) begin
            case (reg_addr)
               OFS_HUND: if (wr_hold) vis_q.hund <= reg_wdata;
               OFS_SEC: begin
                  stop_q <= reg_wdata[7];
                  if (wr_hold) vis_q.sec <= {1'b0, reg_wdata[6:0]};
               end
               OFS_MIN:  if (wr_hold) vis_q.min  <= {1'b0, reg_wdata[6:0]};
               OFS_HR:   if (wr_hold) vis_q.hr   <= {2'b00, reg_wdata[5:0]};
               OFS_DOW: if (wr_hold) begin
                  vis_q.dow <= {5'b00000, reg_wdata[2:0]};
                  ft_q      <= reg_wdata[6];
               end
               OFS_DATE: if (wr_hold) vis_q.date <= {2'b00, reg_wdata[5:0]};
               OFS_MON:  if (wr_hold) vis_q.mon  <= {3'b000, reg_wdata[4:0]};
               OFS_YR:   if (wr_hold) vis_q.yr   <= reg_wdata;
               OFS_CTRL: ctrl_q <= reg_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (reg_addr)
         OFS_HUND: reg_rdata = vis_q.hund;
         OFS_SEC:  reg_rdata = {stop_q, vis_q.sec[6:1], ft_q ? ft_tog : vis_q.sec[0]};
         OFS_MIN:  reg_rdata = vis_q.min;
         OFS_HR:   reg_rdata = vis_q.hr;
         OFS_DOW:  reg_rdata = {1'b0, ft_q, 3'b000, vis_q.dow[2:0]};
         OFS_DATE: reg_rdata = vis_q.date;
         OFS_MON:  reg_rdata = vis_q.mon;
         OFS_YR:   reg_rdata = vis_q.yr;
         OFS_CTRL: reg_rdata = ctrl_q;
         default:  reg_rdata = 8'h00;
      endcase
   end

   assign osc_stop  = stop_q;
   assign load      = reg_we && (reg_addr == OFS_CTRL) && wr_hold && !reg_wdata[WR_HOLD_BIT];
   assign load_time = vis_q;

   // R4: read hold alone freezes the visible time
   a_r4_read_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[RD_HOLD_BIT] && !wr_hold) |=> $stable(vis_q));

   // R6: without write hold, no host write alters the visible time except a refresh
   a_r6_no_write_when_open: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hold && !roll_now) |=> $stable(vis_q));

   // R9: test enable changes only under write hold
   a_r9_ft_guarded: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hold |=> $stable(ft_q));

endmodule

// File: rtl/rtc_frozen_view_clock.sv
module rtc_frozen_view_clock
   import rtc_bcd_pkg::*;
#(
   parameter int   ADDR_W        = 4,
   parameter bit   FTEST_EN      = 1'b1,
   parameter logic RESET_STOPPED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_100,
   input  logic              tick_512,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata
);

   localparam int REG_COUNT = 9;

   generate
      if ((1 << ADDR_W) < REG_COUNT) begin : g_addr_chk
         $error("ADDR_W too small for the register bank");
      end
   endgenerate

   rtc_time_t cur_time, nxt_time, load_time;
   logic      roll_now, osc_stop, load, ft_tog;

   rtc_time_counter u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_100),
      .run       (!osc_stop),
      .load      (load),
      .load_time (load_time),
      .cur_time  (cur_time),
      .nxt_time  (nxt_time),
      .roll_now  (roll_now)
   );

   generate
      if (FTEST_EN) begin : g_ftest
         rtc_ftest_toggle u_tog (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_512),
            .tog   (ft_tog)
         );
      end else begin : g_no_ftest
         assign ft_tog = 1'b0;
      end
   endgenerate

   rtc_view_regs #(
      .ADDR_W        (ADDR_W),
      .RESET_STOPPED (RESET_STOPPED)
   ) u_view (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .roll_now  (roll_now),
      .nxt_time  (nxt_time),
      .ft_tog    (ft_tog),
      .osc_stop  (osc_stop),
      .load      (load),
      .load_time (load_time)
   );

   // R3: an unheld wrap leaves visible time equal to the counters
   a_r3_refresh_matches: assert property (@(posedge clk) disable iff (!rst_n)
      (roll_now && !load && !u_view.ctrl_q[7] && !u_view.ctrl_q[6]) |=> (load_time == cur_time));

endmodule

// File: tb/rtc_frozen_view_clock_tb.sv
module rtc_frozen_view_clock_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_100 = 1'b0;
   logic       tick_512 = 1'b0;
   logic       reg_we = 1'b0;
   logic [3:0] reg_addr = 4'h0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rtc_frozen_view_clock u_dut (
      .clk(clk), .rst_n(rst_n), .tick_100(tick_100), .tick_512(tick_512),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; reg_we = 1'b0; tick_100 = 1'b0; tick_512 = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         tick_100 = 1'b1;
         @(negedge clk);
         tick_100 = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic pulse512();
      tick_512 = 1'b1;
      @(negedge clk);
      tick_512 = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] yr, mon, date, dow, hr, mn, sc, hu);
      wr(4'h8, 8'h80);
      wr(4'h7, yr); wr(4'h6, mon); wr(4'h5, date); wr(4'h4, dow);
      wr(4'h3, hr); wr(4'h2, mn); wr(4'h1, sc); wr(4'h0, hu);
      wr(4'h8, 8'h00);
   endtask

   task automatic t_reset_state();
      logic [7:0] v;
      logic [7:0] exp [0:9];
      exp = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
      do_reset();
      for (int a = 0; a < 10; a++) begin
         rd(4'(a), v);
         check($sformatf("R1 reset offset %0d", a), v, exp[a]);
      end
   endtask

   task automatic t_counting();
      logic [7:0] v;
      do_reset();
      tick(100);
      rd(4'h1, v); check("R2 one second", v, 8'h01);
      rd(4'h0, v); check("R3 hundredths at refresh", v, 8'h00);
      tick(99);
      rd(4'h1, v); check("R3 no refresh before wrap", v, 8'h01);
      tick(1);
      rd(4'h1, v); check("R3 refresh on wrap", v, 8'h02);
      set_time(8'h24, 8'h05, 8'h06, 8'h03, 8'h09, 8'h59, 8'h59, 8'h99);
      tick(1);
      rd(4'h2, v); check("R2 minute carry", v, 8'h00);
      rd(4'h3, v); check("R2 hour carry", v, 8'h10);
   endtask

   task automatic t_read_hold();
      logic [7:0] v;
      do_reset();
      tick(100);
      wr(4'h8, 8'h40);
      tick(100);
      rd(4'h1, v); check("R4 frozen under read hold", v, 8'h01);
      wr(4'h8, 8'h00);
      tick(100);
      rd(4'h1, v); check("R4 R7 counters kept running", v, 8'h03);
   endtask

   task automatic t_hold_at_wrap();
      logic [7:0] v;
      do_reset();
      tick(99);
      tick_100 = 1'b1; reg_we = 1'b1; reg_addr = 4'h8; reg_wdata = 8'h40;
      @(negedge clk);
      tick_100 = 1'b0; reg_we = 1'b0;
      @(negedge clk);
      rd(4'h1, v); check("R5 refresh completes with hold", v, 8'h01);
      tick(100);
      rd(4'h1, v); check("R5 frozen afterwards", v, 8'h01);
      wr(4'h8, 8'h00);
   endtask

   task automatic t_write_hold();
      logic [7:0] v;
      do_reset();
      wr(4'h2, 8'h45);
      rd(4'h2, v); check("R6 write ignored without hold", v, 8'h00);
      wr(4'h8, 8'h80);
      wr(4'h2, 8'h45);
      rd(4'h2, v); check("R6 write taken under hold", v, 8'h45);
      tick(100);
      rd(4'h1, v); check("R6 no refresh under write hold", v, 8'h00);
      rd(4'h2, v); check("R6 written minute kept", v, 8'h45);
      wr(4'h8, 8'h00);
      tick(100);
      rd(4'h2, v); check("R7 loaded minute", v, 8'h45);
      rd(4'h1, v); check("R7 continues from load", v, 8'h01);
   endtask

   task automatic t_stop();
      logic [7:0] v;
      do_reset();
      wr(4'h1, 8'h80);
      rd(4'h1, v); check("R8 stop bit reads back", v, 8'h80);
      tick(150);
      rd(4'h1, v); check("R8 no refresh while stopped", v, 8'h80);
      wr(4'h1, 8'h00);
      tick(100);
      rd(4'h1, v); check("R8 resumed after stop", v, 8'h01);
   endtask

   task automatic t_ftest();
      logic [7:0] v;
      do_reset();
      wr(4'h4, 8'h41);
      rd(4'h4, v); check("R9 test bit ignored without hold", v, 8'h01);
      wr(4'h8, 8'h80);
      wr(4'h4, 8'h41);
      rd(4'h4, v); check("R9 test bit set", v, 8'h41);
      rd(4'h1, v); check("R9 toggle starts low", v, 8'h00);
      pulse512();
      rd(4'h1, v); check("R9 toggle after one tick", v, 8'h01);
      pulse512();
      rd(4'h1, v); check("R9 toggle after two ticks", v, 8'h00);
      pulse512();
      wr(4'h4, 8'h01);
      rd(4'h1, v); check("R9 normal seconds when off", v, 8'h00);
      wr(4'h8, 8'h00);
   endtask

   task automatic t_rollover(input string tag, input logic [7:0] yr, mon, date, dow,
                             input logic [7:0] e_yr, e_mon, e_date, e_dow);
      logic [7:0] v;
      do_reset();
      set_time(yr, mon, date, dow, 8'h23, 8'h59, 8'h59, 8'h99);
      tick(1);
      rd(4'h7, v); check({"R10 year ", tag}, v, e_yr);
      rd(4'h6, v); check({"R10 month ", tag}, v, e_mon);
      rd(4'h5, v); check({"R10 date ", tag}, v, e_date);
      rd(4'h4, v); check({"R10 weekday ", tag}, v, e_dow);
      rd(4'h3, v); check({"R2 hour wrap ", tag}, v, 8'h00);
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_counting();
      t_read_hold();
      t_hold_at_wrap();
      t_write_hold();
      t_stop();
      t_ftest();
      t_rollover("leap feb", 8'h04, 8'h02, 8'h28, 8'h07, 8'h04, 8'h02, 8'h29, 8'h01);
      t_rollover("plain feb", 8'h03, 8'h02, 8'h28, 8'h02, 8'h03, 8'h03, 8'h01, 8'h03);
      t_rollover("april", 8'h10, 8'h04, 8'h30, 8'h05, 8'h10, 8'h05, 8'h01, 8'h06);
      t_rollover("century", 8'h99, 8'h12, 8'h31, 8'h07, 8'h00, 8'h01, 8'h01, 8'h01);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule